// File: doc/BRIEF.md
# KCS Host Transfer Sequencer

This block is the host-side engine for a keyboard-controller-style channel to a management controller. Software or a host-side agent fills a small request buffer, gives a length and a start pulse, and the sequencer moves the request byte by byte into the channel. It uses the standard KCS control codes and follows the phase field that the management controller writes into the status byte. When the controller returns to idle, the sequencer collects the reply bytes into a response buffer and reports the reply length with a single-cycle done pulse.

The engine is event driven. It re-examines the channel whenever the input-buffer-full flag falls, the output-buffer-full flag rises, or a new request is accepted. It then performs at most one host access per cycle: a read of the output data, or a write of a data or command byte. If the controller signals an error phase, the engine abandons the transfer and issues the abort code.

Top module: `kcs_host_seq`

## Requirements
- R1: After reset, no channel read or write is issued and `rsp_done` is low.
- R2: Status byte layout: bits 7:6 give the phase (0 idle, 1 read, 2 write, 3 error), bit 1 is input-full, bit 0 is output-full. In the idle phase with a request pending, the engine writes 0x61 as a command byte.
- R3: In the write phase, the engine sends the next request byte as data only when input-full is clear. Before the final request byte, it first sends 0x62 as a command, then that final byte as data.
- R4: In the read phase with output-full set, the engine reads the byte, stores it as the next response byte, and then writes 0x68 as data.
- R5: In the idle phase with output-full set, the engine reads and discards one byte. If any response bytes have been stored, it pulses `rsp_done` for one cycle, with `rsp_len` equal to the stored count, and then resets the count to zero.
- R6: In the error phase, the engine reads any pending output byte, discards both the pending request and the stored response, and writes 0x60 as a command if input-full is clear. No done pulse is produced for the aborted transfer.
- R7: A start that arrives while a request is still pending is dropped.
- R8: A start with a length of zero is ignored and causes no channel access.
- R9: A request longer than MAX_MSG bytes is cut to its first MAX_MSG bytes.
- R10: Response bytes beyond MAX_MSG are discarded, so `rsp_len` never exceeds MAX_MSG.
- R11: Read and write strobes are never high together, and two consecutive cycles never both carry a channel write.
- R12: Writes into the request buffer while a request is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr_en | input | 1 | Request buffer write strobe |
| req_wr_addr | input | AW | Request buffer byte index |
| req_wr_data | input | 8 | Request buffer byte |
| req_start | input | 1 | Start a transfer of `req_len` bytes |
| req_len | input | LEN_IN_W | Requested length in bytes |
| ch_status | input | 8 | Channel status byte (phase, flags) |
| ch_rd_en | output | 1 | Read strobe for the channel output data |
| ch_rd_data | input | 8 | Channel output data, valid while `ch_rd_en` is high |
| ch_wr_en | output | 1 | Write strobe toward the channel input register |
| ch_wr_is_cmd | output | 1 | 1 = command write, 0 = data write |
| ch_wr_data | output | 8 | Byte written to the channel |
| rsp_rd_addr | input | AW | Response buffer read index |
| rsp_rd_data | output | 8 | Response byte at `rsp_rd_addr` (combinational) |
| rsp_done | output | 1 | One-cycle pulse when a response is delivered |
| rsp_len | output | CW | Response length, valid with `rsp_done` |

## Verification
The bench builds the block with MAX_MSG set to 8 and LEN_IN_W set to 8. With these values, requests of up to 12 bytes and replies of up to 11 bytes go past the buffer size within a few dozen cycles, so both truncation paths are exercised repeatedly. A behavioural controller model with a random reply delay of 0 to 3 cycles drives the phase field. It can inject an error after any received request byte, which exercises abort, drop and ignore paths in the middle of a transfer.

// File: rtl/kcs_host_pkg.sv
package kcs_host_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2,
    PH_ERROR = 2'd3
  } kcs_phase_e;

  typedef enum logic [1:0] {
    EX_WAIT = 2'd0,
    EX_RD   = 2'd1,
    EX_WR   = 2'd2
  } exec_e;

  localparam logic [7:0] CODE_ABORT  = 8'h60;
  localparam logic [7:0] CODE_WSTART = 8'h61;
  localparam logic [7:0] CODE_WEND   = 8'h62;
  localparam logic [7:0] CODE_RDACK  = 8'h68;

  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;

  typedef struct packed {
    logic       do_rd;
    logic       keep;
    logic       do_wr;
    logic       wr_cmd;
    logic [7:0] wr_byte;
  } host_plan_t;

  function automatic kcs_phase_e phase_of(input logic [7:0] st);
    return kcs_phase_e'(st[7:6]);
  endfunction

endpackage

// File: rtl/kcs_evt_det.sv
module kcs_evt_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ibf,
  input  logic obf,
  output logic evt
);
  logic ibf_q, obf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibf_q <= 1'b0;
      obf_q <= 1'b0;
    end else begin
      ibf_q <= ibf;
      obf_q <= obf;
    end
  end

  // controller consumed our byte, or controller produced a byte
  assign evt = (ibf_q & ~ibf) | (~obf_q & obf);
endmodule

// File: rtl/kcs_req_store.sv
module kcs_req_store #(
  parameter int MAX_MSG  = 64,
  parameter int LEN_IN_W = 8,
  parameter int AW       = 6,
  parameter int CW       = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                start,
  input  logic [LEN_IN_W-1:0] len,
  input  logic                adv,
  input  logic                clr,
  output logic                accepted,
  output logic [CW-1:0]       pend_len,
  output logic                is_last,
  output logic [7:0]          cur_byte
);
  logic [7:0]    mem [MAX_MSG];
  logic [CW-1:0] pos_q, len_q;

  function automatic logic [CW-1:0] fit_len(input logic [LEN_IN_W-1:0] n);
    if (n > LEN_IN_W'(MAX_MSG)) return CW'(MAX_MSG);
    return CW'(n);
  endfunction

  assign accepted = start && (len_q == '0) && (len != '0);

  always_ff @(posedge clk) begin
    if (wr_en && (len_q == '0))
      mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      len_q <= '0;
    end else if (accepted) begin
      pos_q <= '0;
      len_q <= fit_len(len);
    end else if (clr) begin
      pos_q <= '0;
      len_q <= '0;
    end else if (adv) begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign pend_len = len_q;
  assign is_last  = (len_q != '0) && (pos_q == len_q - 1'b1);
  assign cur_byte = mem[pos_q[AW-1:0]];
endmodule

// File: rtl/kcs_rsp_store.sv
module kcs_rsp_store #(
  parameter int MAX_MSG = 64,
  parameter int AW      = 6,
  parameter int CW      = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          clr,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] cnt
);
  logic [7:0]    mem [MAX_MSG];
  logic [CW-1:0] cnt_q;
  logic          room;

  assign room = (cnt_q < CW'(MAX_MSG));

  always_ff @(posedge clk) begin
    if (push && room)
      mem[cnt_q[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (push && room)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt     = cnt_q;
  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/kcs_host_seq.sv
module kcs_host_seq
  import kcs_host_pkg::*;
#(
  parameter int MAX_MSG  = 64,
  parameter int LEN_IN_W = 8,
  localparam int AW      = (MAX_MSG > 2) ? $clog2(MAX_MSG) : 1,
  localparam int CW      = $clog2(MAX_MSG + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_wr_en,
  input  logic [AW-1:0]       req_wr_addr,
  input  logic [7:0]          req_wr_data,
  input  logic                req_start,
  input  logic [LEN_IN_W-1:0] req_len,
  input  logic [7:0]          ch_status,
  output logic                ch_rd_en,
  input  logic [7:0]          ch_rd_data,
  output logic                ch_wr_en,
  output logic                ch_wr_is_cmd,
  output logic [7:0]          ch_wr_data,
  input  logic [AW-1:0]       rsp_rd_addr,
  output logic [7:0]          rsp_rd_data,
  output logic                rsp_done,
  output logic [CW-1:0]       rsp_len
);
  // named internal events
  logic          evt_w, req_acc_w, eval_go_w;
  logic [CW-1:0] pend_len_w, rsp_cnt_w;
  logic          is_last_w;
  logic [7:0]    cur_byte_w;

  logic       ibf, obf;
  kcs_phase_e phase;
  assign ibf   = ch_status[ST_IBF];
  assign obf   = ch_status[ST_OBF];
  assign phase = phase_of(ch_status);

  exec_e      ex_q, ex_d;
  host_plan_t plan_d, plan_q;
  logic       eval_pend_q, last_hold_q;
  logic       adv, clr_req, clr_rsp, set_last, drop_last, deliver;
  logic       done_q;
  logic [CW-1:0] len_q;

  kcs_evt_det u_evt (
    .clk(clk), .rst_n(rst_n), .ibf(ibf), .obf(obf), .evt(evt_w)
  );

  kcs_req_store #(.MAX_MSG(MAX_MSG), .LEN_IN_W(LEN_IN_W), .AW(AW), .CW(CW)) u_req (
    .clk(clk), .rst_n(rst_n),
    .wr_en(req_wr_en), .wr_addr(req_wr_addr), .wr_data(req_wr_data),
    .start(req_start), .len(req_len),
    .adv(adv), .clr(clr_req),
    .accepted(req_acc_w), .pend_len(pend_len_w),
    .is_last(is_last_w), .cur_byte(cur_byte_w)
  );

  kcs_rsp_store #(.MAX_MSG(MAX_MSG), .AW(AW), .CW(CW)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .push((ex_q == EX_RD) && plan_q.keep), .push_data(ch_rd_data),
    .clr(clr_rsp), .rd_addr(rsp_rd_addr), .rd_data(rsp_rd_data),
    .cnt(rsp_cnt_w)
  );

  assign eval_go_w = (ex_q == EX_WAIT) && eval_pend_q;

  // decision taken once per evaluation
  always_comb begin
    plan_d    = '0;
    adv       = 1'b0;
    clr_req   = 1'b0;
    clr_rsp   = 1'b0;
    set_last  = 1'b0;
    drop_last = 1'b0;
    deliver   = 1'b0;
    if (eval_go_w) begin
      unique case (phase)
        PH_IDLE: begin
          if (obf) begin
            plan_d.do_rd = 1'b1;
            if (rsp_cnt_w != '0) begin
              deliver = 1'b1;
              clr_rsp = 1'b1;
            end
          end
          if (pend_len_w != '0) begin
            plan_d.do_wr   = 1'b1;
            plan_d.wr_cmd  = 1'b1;
            plan_d.wr_byte = CODE_WSTART;
            set_last       = 1'b1;
          end
        end
        PH_READ: begin
          if (obf) begin
            plan_d.do_rd   = 1'b1;
            plan_d.keep    = 1'b1;
            plan_d.do_wr   = 1'b1;
            plan_d.wr_byte = CODE_RDACK;
          end
        end
        PH_WRITE: begin
          if (!ibf && (pend_len_w != '0)) begin
            plan_d.do_wr = 1'b1;
            if (last_hold_q && is_last_w) begin
              plan_d.wr_cmd  = 1'b1;
              plan_d.wr_byte = CODE_WEND;
              drop_last      = 1'b1;
            end else begin
              plan_d.wr_byte = cur_byte_w;
              adv            = 1'b1;
              if (!last_hold_q) clr_req = 1'b1;
            end
          end
        end
        PH_ERROR: begin
          plan_d.do_rd = obf;
          clr_req      = 1'b1;
          clr_rsp      = 1'b1;
          drop_last    = 1'b1;
          if (!ibf) begin
            plan_d.do_wr   = 1'b1;
            plan_d.wr_cmd  = 1'b1;
            plan_d.wr_byte = CODE_ABORT;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ex_d = ex_q;
    unique case (ex_q)
      EX_WAIT: if (eval_go_w) begin
                 if (plan_d.do_rd)      ex_d = EX_RD;
                 else if (plan_d.do_wr) ex_d = EX_WR;
               end
      EX_RD:   ex_d = plan_q.do_wr ? EX_WR : EX_WAIT;
      EX_WR:   ex_d = EX_WAIT;
      default: ex_d = EX_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_q        <= EX_WAIT;
      plan_q      <= '0;
      eval_pend_q <= 1'b0;
      last_hold_q <= 1'b0;
      done_q      <= 1'b0;
      len_q       <= '0;
    end else begin
      ex_q        <= ex_d;
      eval_pend_q <= (eval_pend_q && !eval_go_w) || evt_w || req_acc_w;
      if (eval_go_w) plan_q <= plan_d;
      if (set_last)                  last_hold_q <= 1'b1;
      else if (drop_last || clr_req) last_hold_q <= 1'b0;
      done_q <= deliver;
      if (deliver) len_q <= rsp_cnt_w;
    end
  end

  assign ch_rd_en     = (ex_q == EX_RD);
  assign ch_wr_en     = (ex_q == EX_WR);
  assign ch_wr_is_cmd = plan_q.wr_cmd;
  assign ch_wr_data   = plan_q.wr_byte;
  assign rsp_done     = done_q;
  assign rsp_len      = done_q ? len_q : '0;
endmodule

// File: rtl/kcs_host_seq_chk.sv
module kcs_host_seq_chk #(
  parameter int MAX_MSG = 64,
  parameter int CW      = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    ch_status,
  input logic          ch_rd_en,
  input logic          ch_wr_en,
  input logic          ch_wr_is_cmd,
  input logic [7:0]    ch_wr_data,
  input logic          rsp_done,
  input logic [CW-1:0] rsp_len,
  input logic [CW-1:0] pend_len,
  input logic [CW-1:0] rsp_cnt
);
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch_rd_en && ch_wr_en)); // R11
  AST_NO_B2B_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wr_en |=> !ch_wr_en); // R11
  AST_RD_ON_OBF: assert property (@(posedge clk) disable iff (!rst_n)
    ch_rd_en |-> ch_status[0]); // R4
  AST_CMD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_wr_en && ch_wr_is_cmd) |-> (ch_wr_data inside {8'h60, 8'h61, 8'h62})); // R2
  AST_START_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_wr_en && ch_wr_is_cmd && ch_wr_data == 8'h61) |-> (pend_len != '0)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R5
  AST_DONE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_done) |-> ($past(ch_status[7:6]) == 2'd0)); // R5
  AST_DONE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (rsp_len != '0 && rsp_len <= CW'(MAX_MSG))); // R10
  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_len <= CW'(MAX_MSG)); // R9
  AST_RSP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cnt <= CW'(MAX_MSG)); // R10
endmodule

bind kcs_host_seq kcs_host_seq_chk #(.MAX_MSG(MAX_MSG), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ch_status(ch_status),
  .ch_rd_en(ch_rd_en), .ch_wr_en(ch_wr_en), .ch_wr_is_cmd(ch_wr_is_cmd),
  .ch_wr_data(ch_wr_data), .rsp_done(rsp_done), .rsp_len(rsp_len),
  .pend_len(pend_len_w), .rsp_cnt(rsp_cnt_w)
);

// File: tb/kcs_host_seq_tb.sv
module kcs_host_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX = 8;
  localparam int LW  = 8;
  localparam int AW  = 3;
  localparam int CW  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_wr_en = 1'b0, req_start = 1'b0;
  logic [AW-1:0] req_wr_addr = '0, rsp_rd_addr = '0;
  logic [7:0] req_wr_data = '0;
  logic [LW-1:0] req_len = '0;
  logic [7:0] ch_status, ch_rd_data, ch_wr_data, rsp_rd_data;
  logic ch_rd_en, ch_wr_en, ch_wr_is_cmd, rsp_done;
  logic [CW-1:0] rsp_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  kcs_host_seq #(.MAX_MSG(MAX), .LEN_IN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_wr_en(req_wr_en), .req_wr_addr(req_wr_addr),
    .req_wr_data(req_wr_data), .req_start(req_start), .req_len(req_len),
    .ch_status(ch_status), .ch_rd_en(ch_rd_en), .ch_rd_data(ch_rd_data),
    .ch_wr_en(ch_wr_en), .ch_wr_is_cmd(ch_wr_is_cmd), .ch_wr_data(ch_wr_data),
    .rsp_rd_addr(rsp_rd_addr), .rsp_rd_data(rsp_rd_data),
    .rsp_done(rsp_done), .rsp_len(rsp_len)
  );

  int n_chk = 0, n_fail = 0;

  function automatic int fit(input int n);
    return (n > MAX) ? MAX : n;
  endfunction
  function automatic logic [7:0] rbyte(input logic [7:0] base, input int i);
    return 8'(base + 8'(i * 37) + 8'h05);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // controller model configuration
  int cfg_len = 0, cfg_rsp = 1, cfg_err = 0, cfg_dly = 0;
  logic [7:0] cfg_base = 8'h00;

  // controller model state
  logic [1:0] m_state;
  logic m_ibf, m_obf, m_cmd, got_end;
  logic [7:0] m_in, m_out;
  logic [7:0] rx [0:63];
  int rx_n, tx_i, dly, seq_err, abort_cnt, done_cnt, wr_cnt, both_cnt;
  logic [CW-1:0] done_len;

  assign ch_status  = {m_state, 2'b00, m_cmd, 1'b0, m_ibf, m_obf};
  assign ch_rd_data = m_out;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state <= 2'd0; m_ibf <= 1'b0; m_obf <= 1'b0; m_cmd <= 1'b0; got_end <= 1'b0;
      m_in <= '0; m_out <= '0; rx_n <= 0; tx_i <= 0; dly <= 0;
      seq_err <= 0; abort_cnt <= 0; done_cnt <= 0; wr_cnt <= 0; both_cnt <= 0;
      done_len <= '0;
    end else begin
      if (ch_rd_en && ch_wr_en) both_cnt <= both_cnt + 1;
      if (ch_rd_en) m_obf <= 1'b0;
      if (m_ibf) begin
        if (dly != 0) dly <= dly - 1;
        else begin
          m_ibf <= 1'b0;
          if (m_cmd) begin
            case (m_in)
              8'h61: begin m_state <= 2'd2; rx_n <= 0; got_end <= 1'b0; end
              8'h62: begin
                if (m_state != 2'd2 || rx_n != cfg_len - 1) seq_err <= seq_err + 1;
                got_end <= 1'b1;
              end
              8'h60: begin m_state <= 2'd0; m_out <= 8'h00; m_obf <= 1'b1; abort_cnt <= abort_cnt + 1; end
              default: seq_err <= seq_err + 1;
            endcase
          end else begin
            case (m_state)
              2'd2: begin
                rx[rx_n] <= m_in;
                rx_n <= rx_n + 1;
                if (cfg_err == rx_n + 1) begin
                  m_state <= 2'd3; m_out <= 8'hEE; m_obf <= 1'b1;
                end else if (got_end) begin
                  if (rx_n + 1 != cfg_len) seq_err <= seq_err + 1;
                  m_state <= 2'd1; m_out <= rbyte(cfg_base, 0); tx_i <= 1; m_obf <= 1'b1;
                end
              end
              2'd1: begin
                if (m_in != 8'h68) seq_err <= seq_err + 1;
                if (tx_i < cfg_rsp) begin
                  m_out <= rbyte(cfg_base, tx_i); tx_i <= tx_i + 1; m_obf <= 1'b1;
                end else begin
                  m_state <= 2'd0; m_out <= 8'h00; m_obf <= 1'b1;
                end
              end
              default: seq_err <= seq_err + 1;
            endcase
          end
        end
      end
      if (ch_wr_en) begin
        m_in <= ch_wr_data; m_cmd <= ch_wr_is_cmd; m_ibf <= 1'b1; dly <= cfg_dly;
        wr_cnt <= wr_cnt + 1;
      end
      if (rsp_done) begin done_cnt <= done_cnt + 1; done_len <= rsp_len; end
    end
  end

  logic [7:0] req_img [0:15];

  task automatic buf_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    req_wr_en = 1'b1; req_wr_addr = AW'(a); req_wr_data = d;
    @(negedge clk);
    req_wr_en = 1'b0;
  endtask

  task automatic kick(input int len);
    @(negedge clk);
    req_start = 1'b1; req_len = LW'(len);
    @(negedge clk);
    req_start = 1'b0;
  endtask

  task automatic run_txn(input int len, input int nrsp, input int err);
    int eff, d0, a0, s0;
    eff = fit(len);
    cfg_len = eff; cfg_rsp = nrsp; cfg_err = err;
    cfg_base = 8'($urandom); cfg_dly = $urandom % 4;
    for (int i = 0; i < eff; i++) begin
      req_img[i] = 8'($urandom);
      buf_wr(i, req_img[i]);
    end
    d0 = done_cnt; a0 = abort_cnt; s0 = seq_err;
    kick(len);
    repeat (40 + 16 * (eff + nrsp)) @(negedge clk);
    chk(seq_err == s0, "R2/R3 control-code order", seq_err - s0, 0);
    if (err == 0) begin
      chk(done_cnt == d0 + 1, "R5 one done pulse", done_cnt - d0, 1);
      chk(int'(done_len) == fit(nrsp), "R10 response length", int'(done_len), fit(nrsp));
      chk(rx_n == eff, "R9 request bytes sent", rx_n, eff);
      for (int i = 0; i < eff; i++)
        chk(rx[i] == req_img[i], "R3 request byte", int'(rx[i]), int'(req_img[i]));
      for (int i = 0; i < fit(nrsp); i++) begin
        rsp_rd_addr = AW'(i);
        #1;
        chk(rsp_rd_data == rbyte(cfg_base, i), "R4 response byte",
            int'(rsp_rd_data), int'(rbyte(cfg_base, i)));
      end
    end else begin
      chk(done_cnt == d0, "R6 no done on abort", done_cnt - d0, 0);
      chk(abort_cnt == a0 + 1, "R6 abort code sent", abort_cnt - a0, 1);
      chk(rx_n == err, "R6 bytes before error", rx_n, err);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int w0, d0, s0;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    chk(!ch_rd_en && !ch_wr_en, "R1 no access in reset", int'(ch_rd_en | ch_wr_en), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ch_rd_en && !ch_wr_en, "R1 no access after reset", int'(ch_rd_en | ch_wr_en), 0);
    chk(!rsp_done, "R1 done low after reset", int'(rsp_done), 0);

    run_txn(1, 1, 0);            // single byte each way, R3 end code first
    run_txn(MAX + 4, 3, 0);      // R9 truncation
    run_txn(4, MAX + 3, 0);      // R10 response overflow
    run_txn(MAX, MAX, 0);

    // R8 zero length
    w0 = wr_cnt; d0 = done_cnt;
    kick(0);
    repeat (30) @(negedge clk);
    chk(wr_cnt == w0, "R8 zero length no access", wr_cnt - w0, 0);
    chk(done_cnt == d0, "R8 zero length no done", done_cnt - d0, 0);

    // R7 drop + R12 buffer write ignored while pending
    cfg_len = 3; cfg_rsp = 2; cfg_err = 0; cfg_dly = 3; cfg_base = 8'h40;
    for (int i = 0; i < 3; i++) begin
      req_img[i] = 8'(8'h10 + i);
      buf_wr(i, req_img[i]);
    end
    d0 = done_cnt; s0 = seq_err;
    kick(3);
    buf_wr(0, 8'hA5);
    kick(5);
    repeat (150) @(negedge clk);
    chk(rx_n == 3, "R7 second start dropped", rx_n, 3);
    chk(rx[0] == 8'h10, "R12 buffer write ignored", int'(rx[0]), 16);
    chk(done_cnt == d0 + 1, "R7 single done", done_cnt - d0, 1);
    chk(seq_err == s0, "R7 sequence intact", seq_err - s0, 0);

    run_txn(5, 2, 3);            // R6 error in middle
    run_txn(2, 2, 0);            // recovery after abort

    for (int k = 0; k < 20; k++) begin
      int len, nr, er;
      len = 1 + $urandom % 12;
      nr  = 1 + $urandom % 11;
      er  = ($urandom % 5 == 0) ? 1 + $urandom % fit(len) : 0;
      run_txn(len, nr, er);
    end

    chk(both_cnt == 0, "R11 one access per cycle", both_cnt, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule